// File: doc/BRIEF.md
# Four-Bank GPIO Register Front End

This block is the register front end of a 128-pin general-purpose I/O controller. The pins are split into four banks of 32. Pin n sits in bank n/32 at bit n%32. For each bank the block stores a direction word, an output latch, a rising-edge enable word, a falling-edge enable word and two alternate-function words. Software never writes the output latch directly. It changes the latch through a set register and a clear register, so a read-modify-write is never needed. A level register returns one merged view of each bank. Bits marked as outputs show the latch, and bits marked as inputs show the sampled pin.

A neighbouring edge-detect block takes the enable words and supplies the captured edge status. This block returns that status on reads and turns writes to the status offsets into a one-cycle clear mask. The alternate-function words are only stored and exported, because pin multiplexing lives elsewhere. The bus is a single-cycle synchronous read/write port with a 9-bit byte offset. Read data is registered.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every stored word and every output latch bit is zero. `pin_out`, `rise_en`, `fall_en`, `alt_cfg` and `edge_clr` are zero, and each mapped register reads zero.
- R2: The byte offsets for banks 0/1/2/3 are fixed as follows. Level: 0x000/0x004/0x008/0x100. Direction: 0x00c/0x010/0x014/0x10c. Set: 0x018/0x01c/0x020/0x118. Clear: 0x024/0x028/0x02c/0x124. Rising enable: 0x030/0x034/0x038/0x130. Falling enable: 0x03c/0x040/0x044/0x13c. Edge status: 0x048/0x04c/0x050/0x148. Bank k data maps to bits [32k+31:32k] of every 128-bit vector.
- R3: A write to a set register ORs the write data into that bank's output latch.
- R4: A write to a clear register removes from that bank's output latch every bit that is 1 in the write data.
- R5: Set and clear registers read as zero.
- R6: Direction bit 1 marks an output. `pin_out` is the output latch ANDed with the direction word.
- R7: A level read returns the latch bits where direction is 1 and the sampled input bits where direction is 0.
- R8: Rising-enable, falling-enable and alternate-function words read back what was written and drive `rise_en`, `fall_en` and `alt_cfg`. Alternate words sit at 0x054/0x05c/0x064/0x06c (low) and 0x058/0x060/0x068/0x070 (high) for banks 0–3. Bank k's low word drives `alt_cfg[64k+31:64k]` and its high word drives `alt_cfg[64k+63:64k+32]`.
- R9: A status read returns the bank's slice of `edge_sts`. A status write drives the write data onto the bank's slice of `edge_clr` for exactly one cycle.
- R10: `rd_notify` pulses for one cycle after each level-register read, and after no other access.
- R11: A read or write at an offset that is not mapped (including offsets with nonzero low two bits) returns zero, changes no state and pulses `bus_err` for one cycle. A write to a level register is ignored without error.
- R12: `bus_rdata`, `rd_notify` and `bus_err` update at the clock edge that samples the access. `pin_in` is registered once before it reaches the level view, so a level read sees the input as it stood one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 9 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle unmapped-access flag |
| rd_notify | output | 1 | One-cycle level-read pulse |
| pin_in | input | 128 | Pin input levels |
| pin_out | output | 128 | Driven pin values |
| rise_en | output | 128 | Rising-edge enables to the edge block |
| fall_en | output | 128 | Falling-edge enables to the edge block |
| alt_cfg | output | 256 | Alternate-function words |
| edge_sts | input | 128 | Edge status from the edge block |
| edge_clr | output | 128 | One-cycle status clear mask |

## Verification
Each bus access has its result due right after the edge that samples it. This covers the read data, the notify and error pulses and the clear mask. Register writes show on `pin_out`, `rise_en`, `fall_en` and `alt_cfg` after that same edge. Input pins reach the level view one edge later. The bench samples two nanoseconds after every rising edge, so it checks the results of the access that edge took. Pin-side checks run only after the bench has idled through the write's edge, and one case deliberately reads in the same cycle that `pin_in` changes, to confirm that the old value is returned.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [8:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         bus_err,
  output logic         rd_notify,
  input  logic [127:0] pin_in,
  output logic [127:0] pin_out,
  output logic [127:0] rise_en,
  output logic [127:0] fall_en,
  output logic [255:0] alt_cfg,
  input  logic [127:0] edge_sts,
  output logic [127:0] edge_clr
);
  localparam int W = 32;
  localparam int NB = 4;
  localparam logic [3:0] K_LVL = 4'd0, K_DIR = 4'd1, K_SET = 4'd2, K_CLR = 4'd3,
                         K_RISE = 4'd4, K_FALL = 4'd5, K_STS = 4'd6, K_ALT = 4'd7,
                         K_NONE = 4'd8;

  logic [W-1:0] dir_r [NB];
  logic [W-1:0] lat_r [NB];
  logic [W-1:0] rise_r[NB];
  logic [W-1:0] fall_r[NB];
  logic [W-1:0] samp_r[NB];
  logic [W-1:0] alt_r [2*NB];

  logic [3:0] kind;
  logic [1:0] bank;
  logic       hi;
  logic [5:0] word, aidx;
  logic [W-1:0] rd_mux;

  assign word = bus_addr[7:2];
  assign aidx = word - 6'd21;

  always_comb begin
    kind = K_NONE;
    bank = 2'd0;
    hi   = 1'b0;
    if (bus_addr[1:0] == 2'b00) begin
      if (!bus_addr[8]) begin
        if (word < 6'd21) begin
          kind = 4'(word / 6'd3);
          bank = 2'(word % 6'd3);
        end else if (word < 6'd29) begin
          kind = K_ALT;
          bank = aidx[2:1];
          hi   = aidx[0];
        end
      end else if (word < 6'd21 && (word % 6'd3) == 6'd0) begin
        kind = 4'(word / 6'd3);
        bank = 2'd3;
      end
    end
  end

  always_comb begin
    case (kind)
      K_LVL:   rd_mux = (lat_r[bank] & dir_r[bank]) | (samp_r[bank] & ~dir_r[bank]);
      K_DIR:   rd_mux = dir_r[bank];
      K_RISE:  rd_mux = rise_r[bank];
      K_FALL:  rd_mux = fall_r[bank];
      K_STS:   rd_mux = edge_sts[{bank, 5'b0} +: W];
      K_ALT:   rd_mux = alt_r[{bank, hi}];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        dir_r[b]  <= '0;
        lat_r[b]  <= '0;
        rise_r[b] <= '0;
        fall_r[b] <= '0;
        samp_r[b] <= '0;
      end
      for (int a = 0; a < 2*NB; a++) alt_r[a] <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      rd_notify <= 1'b0;
      edge_clr  <= '0;
    end else begin
      for (int b = 0; b < NB; b++) samp_r[b] <= pin_in[b*W +: W];
      edge_clr  <= '0;
      rd_notify <= bus_rd && (kind == K_LVL);
      bus_err   <= (bus_rd || bus_wr) && (kind == K_NONE);
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr) begin
        case (kind)
          K_DIR:  dir_r[bank]  <= bus_wdata;
          K_SET:  lat_r[bank]  <= lat_r[bank] | bus_wdata;
          K_CLR:  lat_r[bank]  <= lat_r[bank] & ~bus_wdata;
          K_RISE: rise_r[bank] <= bus_wdata;
          K_FALL: fall_r[bank] <= bus_wdata;
          K_STS:  edge_clr[{bank, 5'b0} +: W] <= bus_wdata;
          K_ALT:  alt_r[{bank, hi}] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign pin_out[b*W +: W] = lat_r[b] & dir_r[b];
    assign rise_en[b*W +: W] = rise_r[b];
    assign fall_en[b*W +: W] = fall_r[b];
    assign alt_cfg[2*b*W +: W]     = alt_r[2*b];
    assign alt_cfg[(2*b+1)*W +: W] = alt_r[2*b+1];
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_rd,
  input logic         bus_wr,
  input logic [8:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic         bus_err,
  input logic         rd_notify,
  input logic [127:0] edge_clr
);
  a_r10_notify_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 9'h000 |=> rd_notify);
  a_r10_notify_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_notify |-> $past(bus_rd));
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));
  a_r11_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 9'h074 |=> bus_rdata == 32'h0 && bus_err);
  a_r5_write_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == 9'h018 || bus_addr == 9'h124) |=> bus_rdata == 32'h0);
  a_r9_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 9'h048 |=> edge_clr[31:0] == $past(bus_wdata));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk chk_i (.*);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err, rd_notify;
  logic [127:0] pin_in = '0, pin_out, rise_en, fall_en, edge_sts = '0, edge_clr;
  logic [255:0] alt_cfg;

  always #4 clk = ~clk;

  gpio_bank_regs dut_i (.*);

  typedef struct {
    logic [31:0]  d;
    bit           chk_d;
    bit           ntf;
    bit           err;
    logic [127:0] clr;
    string        tag;
  } item_t;
  item_t sb[$];
  int vecs = 0, errs = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input bit ntf, input bit err, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.d = exp; it.chk_d = 1'b1; it.ntf = ntf; it.err = err; it.clr = '0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [127:0] clr, input bit err, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    it.d = '0; it.chk_d = 1'b0; it.ntf = 1'b0; it.err = err; it.clr = clr; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    bit took;
    item_t it;
    took = rst_n && (bus_rd || bus_wr);
    #2;
    if (took) begin
      if (sb.size() == 0) begin
        vecs++; errs++;
        $display("FAIL scoreboard: actual result with no expected item, expected none");
      end else begin
        it = sb.pop_front();
        if (it.chk_d) chk({it.tag, " rdata"}, 256'(bus_rdata), 256'(it.d));
        chk({it.tag, " notify"}, 256'(rd_notify), 256'(it.ntf));
        chk({it.tag, " err"}, 256'(bus_err), 256'(it.err));
        chk({it.tag, " clr"}, 256'(edge_clr), 256'(it.clr));
      end
    end
  end

  initial begin
    #800000;
    vecs++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [8:0] zlist [10] = '{9'h000, 9'h00c, 9'h030, 9'h03c, 9'h048, 9'h054, 9'h070, 9'h100, 9'h10c, 9'h148};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", 256'(pin_out), 256'h0);
    chk("R1 enables", 256'({rise_en, fall_en}), 256'h0);
    chk("R1 alt", alt_cfg, 256'h0);
    for (int i = 0; i < 10; i++)
      rd(zlist[i], 32'h0, zlist[i] == 9'h000 || zlist[i] == 9'h100, 1'b0, "R1 reg zero");
    idle();

    // R3 R6 R7 bank 0
    pin_in[31:0] = 32'hAAAA_AAAA;
    wr(9'h00c, 32'h0000_FFFF, '0, 1'b0, "R2 dir0");
    wr(9'h018, 32'hFF00_FF00, '0, 1'b0, "R3 set0");
    idle();
    chk("R6 pin_out bank0", 256'(pin_out), 256'h0000_FF00);
    rd(9'h000, 32'hAAAA_FF00, 1'b1, 1'b0, "R7 level0");
    wr(9'h024, 32'h0F00_0F00, '0, 1'b0, "R4 clr0");
    idle();
    chk("R4 pin_out bank0", 256'(pin_out), 256'h0000_F000);
    rd(9'h000, 32'hAAAA_F000, 1'b1, 1'b0, "R4 level0");
    rd(9'h018, 32'h0, 1'b0, 1'b0, "R5 set read");
    rd(9'h024, 32'h0, 1'b0, 1'b0, "R5 clr read");
    rd(9'h00c, 32'h0000_FFFF, 1'b0, 1'b0, "R2 dir0 read");

    // R2 other banks, R3 accumulation
    wr(9'h010, 32'hFFFF_FFFF, '0, 1'b0, "R2 dir1");
    wr(9'h014, 32'hFFFF_FFFF, '0, 1'b0, "R2 dir2");
    wr(9'h10c, 32'hFFFF_FFFF, '0, 1'b0, "R2 dir3");
    wr(9'h01c, 32'h0000_0001, '0, 1'b0, "R2 set1");
    wr(9'h020, 32'h0000_0002, '0, 1'b0, "R2 set2");
    wr(9'h118, 32'h1234_0000, '0, 1'b0, "R2 set3a");
    wr(9'h118, 32'h0000_5678, '0, 1'b0, "R3 set3b");
    idle();
    chk("R2 pin_out banks", 256'(pin_out), 256'({32'h1234_5678, 32'h2, 32'h1, 32'h0000_F000}));
    rd(9'h100, 32'h1234_5678, 1'b1, 1'b0, "R2 level3");
    wr(9'h124, 32'hFFFF_0000, '0, 1'b0, "R4 clr3");
    rd(9'h100, 32'h0000_5678, 1'b1, 1'b0, "R4 level3");

    // R8 storage and export
    wr(9'h034, 32'hCAFE_0001, '0, 1'b0, "R8 rise1");
    wr(9'h13c, 32'hBEEF_0003, '0, 1'b0, "R8 fall3");
    for (int b = 0; b < 4; b++) begin
      wr(9'(9'h054 + 8*b), 32'hA000_0000 + b, '0, 1'b0, "R8 alt lo");
      wr(9'(9'h058 + 8*b), 32'hB000_0000 + b, '0, 1'b0, "R8 alt hi");
    end
    rd(9'h034, 32'hCAFE_0001, 1'b0, 1'b0, "R8 rise1 read");
    rd(9'h13c, 32'hBEEF_0003, 1'b0, 1'b0, "R8 fall3 read");
    rd(9'h068, 32'hB000_0002, 1'b0, 1'b0, "R8 alt2 hi read");
    idle();
    chk("R8 rise_en", 256'(rise_en), 256'({32'h0, 32'h0, 32'hCAFE_0001, 32'h0}));
    chk("R8 fall_en", 256'(fall_en), 256'({32'hBEEF_0003, 96'h0}));
    chk("R8 alt_cfg", alt_cfg, {32'hB000_0003, 32'hA000_0003, 32'hB000_0002, 32'hA000_0002,
                                32'hB000_0001, 32'hA000_0001, 32'hB000_0000, 32'hA000_0000});

    // R9 status path
    edge_sts = {32'h0, 32'hDEAD_0000, 32'h0, 32'h0000_0011};
    rd(9'h050, 32'hDEAD_0000, 1'b0, 1'b0, "R9 sts2 read");
    rd(9'h048, 32'h0000_0011, 1'b0, 1'b0, "R9 sts0 read");
    wr(9'h148, 32'h0000_0005, {32'h5, 96'h0}, 1'b0, "R9 clr pulse");
    rd(9'h04c, 32'h0, 1'b0, 1'b0, "R9 clr one cycle");

    // R11 unmapped accesses
    rd(9'h074, 32'h0, 1'b0, 1'b1, "R11 unmapped read");
    rd(9'h002, 32'h0, 1'b0, 1'b1, "R11 misaligned read");
    wr(9'h104, 32'hFFFF_FFFF, '0, 1'b1, "R11 hole write");
    wr(9'h01a, 32'hFFFF_FFFF, '0, 1'b1, "R11 misaligned set");
    wr(9'h1fc, 32'hFFFF_FFFF, '0, 1'b1, "R11 top write");
    wr(9'h000, 32'hFFFF_FFFF, '0, 1'b0, "R11 level write ignored");
    idle();
    chk("R11 pin_out unchanged", 256'(pin_out), 256'({32'h0000_5678, 32'h2, 32'h1, 32'h0000_F000}));
    chk("R11 enables unchanged", 256'({rise_en, fall_en}), 256'({32'h0, 32'h0, 32'hCAFE_0001, 32'h0, 32'hBEEF_0003, 96'h0}));

    // R12 input sampling latency
    @(negedge clk);
    pin_in[31:0] = 32'h5555_5555;
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = 9'h000;
    begin
      item_t it;
      it.d = 32'hAAAA_F000; it.chk_d = 1'b1; it.ntf = 1'b1; it.err = 1'b0; it.clr = '0; it.tag = "R12 old sample";
      sb.push_back(it);
    end
    rd(9'h000, 32'h5555_F000, 1'b1, 1'b0, "R12 new sample");
    idle();
    idle();
    chk("R12 queue drained", 256'(sb.size()), 256'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule